// File: doc/BRIEF.md
# SDRAM Open-Row Policy Sequencer

This block sits between a bus arbiter and an SDRAM command generator. For each access handed to it, the block decides whether the SDRAM needs a full access or a fast-page access. A full access is a precharge-all, then an activate, then the read or write. A fast-page access is the read or write alone. The block keeps one open bank and row address with a valid flag. It compares each new SDRAM request against that stored address.

Two policies are selectable. In the hold policy, accesses to other address spaces can come between SDRAM accesses and the row stays open. In the close policy, an access to another space while a row is open is followed at once by a precharge-all. Refresh, self-refresh, standby entry, bus release, a mode-register write, and the clearing of either policy bit all invalidate the open row, so the next SDRAM access is a full one. SDRAM timing is handled outside the block through a command acknowledge input.

Top module: `sdram_row_policy`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd` is NOP (0).
- R2: `cmd` is encoded NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE_ALL=4, DQM_WAIT=5. A miss produces PRECHARGE_ALL, ACTIVATE, then READ or WRITE. `cmd_bank`/`cmd_row` carry the request's bank and row while ACTIVATE is shown.
- R3: An SDRAM request is a hit when the open row is valid, `cfg_page` is 1, and both bank and row match. A hit produces READ or WRITE with no PRECHARGE_ALL or ACTIVATE.
- R4: Every READ, hit or miss, is followed by exactly two DQM_WAIT commands. A WRITE is followed by NOP.
- R5: With `cfg_hold`=1 and `cfg_page`=1, an other-space request (`req_sdram`=0) issues no command, and a later same-row SDRAM request is a hit.
- R6: With the close policy (`cfg_hold`=0 or `cfg_page`=0), an other-space request accepted while a row is open issues PRECHARGE_ALL in the next cycle. The following SDRAM request is then a full access.
- R7: With `cfg_page`=0, every SDRAM request is a full access and `cfg_hold` has no effect.
- R8: A pulse on any of `evt_refresh`, `evt_selfref`, `evt_standby`, `evt_busrel` or `evt_modereg` makes the next SDRAM request a full access.
- R9: A 1-to-0 change of `cfg_hold` or of `cfg_page` makes the next SDRAM request a full access, even if the bit is set again first.
- R10: An event pulse in the same cycle that an SDRAM request is accepted makes that request a miss.
- R11: A command other than NOP stays on `cmd` until `cmd_ack` is 1. `req_ready` is 1 only while `cmd` is NOP and no sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hold | input | 1 | Keep row open across other-space accesses |
| cfg_page | input | 1 | Enable page hits at all |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_sdram | input | 1 | 1 = SDRAM space, 0 = another space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W | Bank address |
| req_row | input | ROW_W | Row address |
| evt_refresh | input | 1 | Refresh cycle occurred |
| evt_selfref | input | 1 | Self-refresh occurred |
| evt_standby | input | 1 | Standby entry |
| evt_busrel | input | 1 | Bus released to an external master |
| evt_modereg | input | 1 | SDRAM mode register written |
| cmd_ack | input | 1 | Command generator took the current command |
| cmd | output | 3 | Command code |
| cmd_bank | output | BA_W | Bank for the command |
| cmd_row | output | ROW_W | Row for the command |

## Verification
The hardest state to reach is a row that is still valid after several intervening accesses, with an invalidating cause arriving at a chosen point. The bench sweeps each policy setting, with and without an other-space access in between, with each of the five event kinds (or none) in an idle cycle, and with the second access on the same or a different row. Further runs place the event in the same cycle as the request and clear a policy bit briefly before a would-be hit.

// File: rtl/srp_pkg.sv
// Shared command encoding for the open-row policy sequencer.
package srp_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PALL = 3'd4,
        CMD_DQMW = 3'd5
    } cmd_e;
    localparam int N_EVT = 5;
endpackage

// File: rtl/srp_force_detect.sv
// Merges the events that invalidate the open row into one pulse.
// The pulse is raised in the same cycle as an event, or as the falling edge of
// either policy bit.
// Assumes events are single-cycle pulses synchronous to clk.
module srp_force_detect
    import srp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hold,
    input  logic             cfg_page,
    input  logic [N_EVT-1:0] evt_i,
    output logic             force_o
);
    logic prev_hold, prev_page;

    // Remember last policy bits so that a clear can be seen as an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_hold <= 1'b0;
            prev_page <= 1'b0;
        end else begin
            prev_hold <= cfg_hold;
            prev_page <= cfg_page;
        end
    end

    // Any event or policy-bit clear forces the next access to be full
    always_comb force_o = (|evt_i) | (prev_hold & ~cfg_hold) | (prev_page & ~cfg_page);
endmodule

// File: rtl/srp_row_track.sv
// Holds the open bank/row and its valid flag, and computes a page hit.
// Clearing takes priority over setting, so an invalidating cause that arrives
// with an activate leaves the row closed.
module srp_row_track #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [BA_W-1:0]  set_bank,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr_i,
    input  logic             force_i,
    input  logic             page_en,
    input  logic [BA_W-1:0]  cmp_bank,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit_o,
    output logic             valid_o
);
    localparam int ADDR_W = BA_W + ROW_W;
    logic [ADDR_W-1:0] open_addr;

    // Track the currently activated row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            open_addr <= '0;
        end else if (clr_i || force_i) begin
            valid_o   <= 1'b0;
        end else if (set_i) begin
            valid_o   <= 1'b1;
            open_addr <= {set_bank, set_row};
        end
    end

    // A hit needs a valid row, page mode, an exact match and no pending force
    always_comb hit_o = valid_o & page_en & ~force_i & (open_addr == {cmp_bank, cmp_row});
endmodule

// File: rtl/srp_seq_fsm.sv
// Command sequencer: accepts one request while idle, then steps through the
// precharge-all / activate / read-write / DQM-wait commands.
// Each command waits for cmd_ack. Assumes the arbiter holds request fields
// stable only in the accept cycle; they are latched here.
module srp_seq_fsm
    import srp_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_sdram,
    input  logic             req_write,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic             hit_i,
    input  logic             row_open_i,
    input  logic             hold_eff_i,
    input  logic             cmd_ack,
    output logic             req_ready,
    output logic [2:0]       cmd,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [ROW_W-1:0] cmd_row,
    output logic             act_done_o,
    output logic             pall_done_o
);
    typedef enum logic [2:0] {S_IDLE, S_PALL, S_ACT, S_RW, S_DQ1, S_DQ2} st_e;
    st_e              st, st_nx;
    logic             cur_wr, pall_only;
    logic [BA_W-1:0]  cur_bank;
    logic [ROW_W-1:0] cur_row;
    logic             accept;

    always_comb accept = req_valid & (st == S_IDLE);

    // Next-state selection from the current step and the acknowledge
    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE: if (accept) begin
                if (req_sdram)                     st_nx = hit_i ? S_RW : S_PALL;
                else if (!hold_eff_i && row_open_i) st_nx = S_PALL;
            end
            S_PALL: if (cmd_ack) st_nx = pall_only ? S_IDLE : S_ACT;
            S_ACT:  if (cmd_ack) st_nx = S_RW;
            S_RW:   if (cmd_ack) st_nx = cur_wr ? S_IDLE : S_DQ1;
            S_DQ1:  if (cmd_ack) st_nx = S_DQ2;
            S_DQ2:  if (cmd_ack) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            cur_wr    <= 1'b0;
            pall_only <= 1'b0;
            cur_bank  <= '0;
            cur_row   <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                pall_only <= ~req_sdram;
                if (req_sdram) begin
                    cur_wr   <= req_write;
                    cur_bank <= req_bank;
                    cur_row  <= req_row;
                end
            end
        end
    end

    // Command decode from the current step
    always_comb begin
        case (st)
            S_PALL:       cmd = CMD_PALL;
            S_ACT:        cmd = CMD_ACT;
            S_RW:         cmd = cur_wr ? CMD_WR : CMD_RD;
            S_DQ1, S_DQ2: cmd = CMD_DQMW;
            default:      cmd = CMD_NOP;
        endcase
    end

    // Handshake and tracker strobes
    always_comb begin
        req_ready   = (st == S_IDLE);
        cmd_bank    = cur_bank;
        cmd_row     = cur_row;
        act_done_o  = (st == S_ACT)  & cmd_ack;
        pall_done_o = (st == S_PALL) & cmd_ack;
    end
endmodule

// File: rtl/sdram_row_policy.sv
// Top of the open-row policy sequencer: joins event merging, row tracking and
// command sequencing. The hold policy is in effect only when both policy bits
// are set.
module sdram_row_policy
    import srp_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hold,
    input  logic             cfg_page,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_sdram,
    input  logic             req_write,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic             evt_refresh,
    input  logic             evt_selfref,
    input  logic             evt_standby,
    input  logic             evt_busrel,
    input  logic             evt_modereg,
    input  logic             cmd_ack,
    output logic [2:0]       cmd,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [ROW_W-1:0] cmd_row
);
    logic force_evt, hit, row_open, act_done, pall_done, hold_eff;

    // Hold bit only counts while page mode is on
    always_comb hold_eff = cfg_hold & cfg_page;

    srp_force_detect u_force (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_page(cfg_page),
        .evt_i({evt_modereg, evt_busrel, evt_standby, evt_selfref, evt_refresh}),
        .force_o(force_evt)
    );

    srp_row_track #(.BA_W(BA_W), .ROW_W(ROW_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .set_i(act_done), .set_bank(cmd_bank), .set_row(cmd_row),
        .clr_i(pall_done), .force_i(force_evt), .page_en(cfg_page),
        .cmp_bank(req_bank), .cmp_row(req_row),
        .hit_o(hit), .valid_o(row_open)
    );

    srp_seq_fsm #(.BA_W(BA_W), .ROW_W(ROW_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_sdram(req_sdram), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row),
        .hit_i(hit), .row_open_i(row_open), .hold_eff_i(hold_eff),
        .cmd_ack(cmd_ack), .req_ready(req_ready),
        .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .act_done_o(act_done), .pall_done_o(pall_done)
    );
endmodule

// File: rtl/srp_row_policy_chk.sv
// Port-level protocol checks for sdram_row_policy, attached by bind.
module srp_row_policy_chk
    import srp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_sdram,
    input logic [4:0] evts,
    input logic       cmd_ack,
    input logic [2:0] cmd
);
    a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cmd == CMD_NOP);
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && !cmd_ack) |=> cmd == $past(cmd));
    a_r4_read_then_dqm: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD && cmd_ack) |=> cmd == CMD_DQMW);
    a_r4_write_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR && cmd_ack) |=> cmd == CMD_NOP);
    a_r2_act_after_pall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd == CMD_ACT) |-> $past(cmd) == CMD_PALL);
    a_r10_event_forces_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_sdram && (|evts)) |=> cmd == CMD_PALL);
endmodule

bind sdram_row_policy srp_row_policy_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sdram(req_sdram),
    .evts({evt_modereg, evt_busrel, evt_standby, evt_selfref, evt_refresh}),
    .cmd_ack(cmd_ack), .cmd(cmd)
);

// File: tb/tb_sdram_row_policy.sv
module tb_sdram_row_policy;
    localparam int BA_W = 2, ROW_W = 13;
    localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PALL = 4, DQMW = 5;

    logic clk = 0, rst_n = 0;
    logic cfg_hold = 0, cfg_page = 0;
    logic req_valid = 0, req_sdram = 0, req_write = 0;
    logic [BA_W-1:0] req_bank = 0;
    logic [ROW_W-1:0] req_row = 0;
    logic [4:0] evt = 0;
    logic cmd_ack = 1;
    logic req_ready;
    logic [2:0] cmd;
    logic [BA_W-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    sdram_row_policy #(.BA_W(BA_W), .ROW_W(ROW_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_page(cfg_page),
        .req_valid(req_valid), .req_ready(req_ready), .req_sdram(req_sdram),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .evt_refresh(evt[0]), .evt_selfref(evt[1]), .evt_standby(evt[2]),
        .evt_busrel(evt[3]), .evt_modereg(evt[4]),
        .cmd_ack(cmd_ack), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One access; returns command sequence packed 3 bits per command
    task automatic run_acc(input logic sd, input logic wr, input logic [BA_W-1:0] b,
                           input logic [ROW_W-1:0] r, input logic [4:0] ev,
                           output logic [23:0] seq, output int n,
                           output logic [BA_W+ROW_W-1:0] act_addr);
        @(negedge clk);
        req_valid = 1; req_sdram = sd; req_write = wr; req_bank = b; req_row = r; evt = ev;
        @(negedge clk);
        req_valid = 0; evt = 0;
        seq = 0; n = 0; act_addr = 0;
        for (int k = 0; k < 16; k++) begin
            if (cmd == NOP) break;
            seq = {seq[20:0], cmd};
            n++;
            if (cmd == ACT) act_addr = {cmd_bank, cmd_row};
            @(negedge clk);
        end
    endtask

    task automatic exp_seq(input bit full, input bit wr, output logic [23:0] seq, output int n);
        seq = 0; n = 0;
        if (full) begin seq = {seq[20:0], PALL}; n++; seq = {seq[20:0], ACT}; n++; end
        seq = {seq[20:0], wr ? WR : RD}; n++;
        if (!wr) begin seq = {seq[20:0], DQMW}; n++; seq = {seq[20:0], DQMW}; n++; end
    endtask

    task automatic pulse_evt(input logic [4:0] ev);
        @(negedge clk); evt = ev;
        @(negedge clk); evt = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] s, e;
        int n, ne;
        logic [BA_W+ROW_W-1:0] aa;
        repeat (3) @(negedge clk);
        check(req_ready === 1 && cmd === NOP, "R1 reset state", {req_ready, cmd}, {1'b1, NOP});
        rst_n = 1;
        @(negedge clk);
        check(req_ready === 1 && cmd === NOP, "R1 after reset", {req_ready, cmd}, {1'b1, NOP});

        // Sweep: policy x intervening other-space x event kind x row match x direction
        for (int cf = 0; cf < 4; cf++)
        for (int it = 0; it < 2; it++)
        for (int ek = 0; ek < 6; ek++)
        for (int sm = 0; sm < 2; sm++)
        for (int wr = 0; wr < 2; wr++) begin
            logic [BA_W-1:0] b0;
            logic [ROW_W-1:0] r0;
            bit hold_eff, full;
            b0 = BA_W'(cf + ek);
            r0 = ROW_W'(ek * 37 + it * 5 + cf);
            cfg_hold = cf[0]; cfg_page = cf[1];
            hold_eff = cf[0] & cf[1];
            pulse_evt(5'b10000);
            // R2: first access always full, activate address correct
            run_acc(1, 0, b0, r0, 0, s, n, aa);
            exp_seq(1, 0, e, ne);
            check(s == e && n == ne, "R2 first access miss", s, e);
            check(aa == {b0, r0}, "R2 activate address", aa, {b0, r0});
            if (it == 1) begin
                run_acc(0, 0, 0, 0, 0, s, n, aa);
                if (hold_eff) check(n == 0, "R5 other space keeps row", s, 0);
                else check(n == 1 && s[2:0] == PALL, "R6 other space precharges", s, PALL);
            end
            if (ek != 0) pulse_evt(5'(1 << (ek - 1)));
            full = !cf[1] || sm == 0 || ek != 0 || (it == 1 && !hold_eff);
            run_acc(1, wr[0], sm ? b0 : b0 ^ 1'b1, sm ? r0 : r0 + 1'b1, 0, s, n, aa);
            exp_seq(full, wr[0], e, ne);
            if (!cf[1]) check(s == e && n == ne, "R7 page off always full", s, e);
            else if (ek != 0) check(s == e && n == ne, "R8 event forces full", s, e);
            else if (full) check(s == e && n == ne, "R2 miss sequence", s, e);
            else check(s == e && n == ne, "R3 R4 hit sequence", s, e);
        end

        // R10: event in the same cycle as a would-be hit
        cfg_hold = 1; cfg_page = 1;
        for (int ek = 0; ek < 5; ek++) begin
            run_acc(1, 1, 2'd1, 13'd100, 0, s, n, aa);
            run_acc(1, 1, 2'd1, 13'd100, 5'(1 << ek), s, n, aa);
            exp_seq(1, 1, e, ne);
            check(s == e && n == ne, "R10 same-cycle event is miss", s, e);
        end

        // R9: brief clear of each policy bit forces full on next hit
        for (int which = 0; which < 2; which++) begin
            run_acc(1, 0, 2'd2, 13'd7, 0, s, n, aa);
            @(negedge clk);
            if (which == 0) cfg_hold = 0; else cfg_page = 0;
            @(negedge clk);
            cfg_hold = 1; cfg_page = 1;
            run_acc(1, 0, 2'd2, 13'd7, 0, s, n, aa);
            exp_seq(1, 0, e, ne);
            check(s == e && n == ne, "R9 policy bit clear forces full", s, e);
        end

        // R5 with hit after several other-space accesses
        run_acc(1, 0, 2'd3, 13'd9, 0, s, n, aa);
        for (int k = 0; k < 3; k++) run_acc(0, k[0], 0, 0, 0, s, n, aa);
        run_acc(1, 0, 2'd3, 13'd9, 0, s, n, aa);
        exp_seq(0, 0, e, ne);
        check(s == e && n == ne, "R5 hit after other spaces", s, e);

        // R11: stall acknowledge on a miss
        @(negedge clk);
        cmd_ack = 0;
        req_valid = 1; req_sdram = 1; req_write = 1; req_bank = 0; req_row = 13'd55;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 3; k++) begin
            check(cmd == PALL && req_ready == 0, "R11 command held without ack", {req_ready, cmd}, {1'b0, PALL});
            @(negedge clk);
        end
        cmd_ack = 1;
        @(negedge clk);
        check(cmd == ACT, "R11 advance on ack", cmd, ACT);
        @(negedge clk);
        check(cmd == WR, "R11 write after activate", cmd, WR);
        @(negedge clk);
        check(cmd == NOP && req_ready == 1, "R4 R11 write returns idle", {req_ready, cmd}, {1'b1, NOP});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule